// File: doc/BRIEF.md
# Per-Row SDRAM Command Broadcaster

This block carries one SDRAM initialisation command out to every populated memory row behind a controller. A request gives a 3-bit command code and a CAS latency. The block first writes a new value to a 16-bit SDRAM control register. That value is a read-modify-write of the register's current contents, with only the command field replaced.

Unless the command is normal operation, the block then visits eight rows in order, two per socket across four sockets. Each row's extent comes from cumulative 8-bit end boundaries in units of 8 MiB. Each populated row gets exactly one dummy read. The read goes to the row's base address, and for a mode-register-set command an offset is added to it. That offset encodes the burst and CAS settings and depends on the row group.

Reads go out one at a time over a request/acknowledge port. A one-cycle done pulse marks the end of the broadcast.

Top module: `sdram_cmd_bcast`

## Requirements
- R1: After reset, ctrl_we_o, rd_req_o and done_o are low.
- R2: start_i accepted while idle gives a one-cycle ctrl_we_o on the next cycle. ctrl_wdata_o equals the ctrl_i value sampled at acceptance, with bits 7..5 replaced by cmd_i; bits 15..8 and 4..0 are unchanged.
- R3: Command code 3'b000 (normal operation) issues no read at all. Other codes: 3'b001 no-op, 3'b010 precharge all, 3'b011 mode register set, 3'b100 refresh; 3'b101..3'b111 behave like a no-op.
- R4: Rows 0 to 7 are handled in ascending order. Row k's end boundary is bound_i[8k+7:8k]. Row 0 starts at 0 and row k starts at row k-1's end boundary, whether or not row k-1 was populated.
- R5: A row gets a read only when its end boundary is strictly greater than its start. Otherwise it is skipped.
- R6: The read address is the row start times 0x800000 plus an offset. The offset is 0 for every code other than 3'b011.
- R7: For 3'b011 at CAS latency 3, the offset is 0x1D0 for rows 0-3 and 0x1E28 for rows 4-7.
- R8: For 3'b011 at cas_lat_i == 2, the offset is 0x150 for rows 0-3 and 0x1EA8 for rows 4-7. Any cas_lat_i other than 2 is treated as 3.
- R9: Only one read is outstanding. rd_req_o and rd_addr_o hold until rd_ack_i is seen high, and the next row is handled only after that.
- R10: done_o pulses for one cycle after row 7 is finished, or right after the register write for code 3'b000. start_i is ignored while a broadcast is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a broadcast |
| cmd_i | input | 3 | Command code |
| cas_lat_i | input | 2 | CAS latency (2 or 3) |
| ctrl_i | input | 16 | Current control register value |
| ctrl_we_o | output | 1 | Control register write strobe |
| ctrl_wdata_o | output | 16 | Control register write value |
| bound_i | input | 64 | Eight row end boundaries, row 0 in the low byte |
| rd_req_o | output | 1 | Dummy read request |
| rd_addr_o | output | 32 | Dummy read byte address |
| rd_ack_i | input | 1 | Read acknowledge |
| done_o | output | 1 | Broadcast finished pulse |

## Verification
The hardest case to reach is a non-monotonic boundary list. In such a list, a row whose end lies below its start must be skipped and must still move the start of the next row downward. The same list has to be run under every command and CAS latency so that the group-dependent offsets are also exercised. The bench reaches this by sweeping all eight codes and four latency values over five boundary lists. One of those lists shrinks, stalls and regrows, and one is populated only in its last row. The acknowledge delay varies from read to read, and one run pulses start again in the middle of a walk.

// File: rtl/sdram_bcast_pkg.sv
package sdram_bcast_pkg;
  localparam int CMD_W     = 3;
  localparam int CMD_LSB   = 5;
  localparam int OFF_W     = 13;

  localparam logic [CMD_W-1:0] CMD_NORMAL = 3'b000;
  localparam logic [CMD_W-1:0] CMD_NOP    = 3'b001;
  localparam logic [CMD_W-1:0] CMD_PALL   = 3'b010;
  localparam logic [CMD_W-1:0] CMD_MRS    = 3'b011;
  localparam logic [CMD_W-1:0] CMD_REF    = 3'b100;

  // mode word: burst 4, interleaved, CAS latency field; placed at address bit 3
  localparam logic [OFF_W-1:0] MRS_OFF_CL3 = 13'h01D0;
  localparam logic [OFF_W-1:0] MRS_OFF_CL2 = 13'h0150;
  // upper row group sees the mode address lines inverted
  localparam logic [OFF_W-1:0] MRS_FLIP    = 13'h1FF8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_WAIT,
    ST_FIN
  } walk_st_e;
endpackage

// File: rtl/sdram_ctrl_merge.sv
module sdram_ctrl_merge
  import sdram_bcast_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [REG_W-1:0] ctrl_i,
  output logic             ctrl_we_o,
  output logic [REG_W-1:0] ctrl_wdata_o
);
  localparam logic [REG_W-1:0] FIELD_MASK = REG_W'(((1 << CMD_W) - 1) << CMD_LSB);

  logic [REG_W-1:0] merged;

  always_comb begin
    merged = ctrl_i;
    merged[CMD_LSB +: CMD_W] = cmd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_we_o    <= 1'b0;
      ctrl_wdata_o <= '0;
    end else begin
      ctrl_we_o <= go_i;
      if (go_i) ctrl_wdata_o <= merged;
    end
  end

  p_we_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_o |=> !ctrl_we_o);
  p_keep_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_we_o) |-> ((ctrl_wdata_o & ~FIELD_MASK) == ($past(ctrl_i) & ~FIELD_MASK)));
endmodule

// File: rtl/sdram_mrs_offset.sv
module sdram_mrs_offset
  import sdram_bcast_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic [ROW_W-1:0] row_i,
  input  logic [1:0]       cas_lat_i,
  input  logic             is_mrs_i,
  output logic [OFF_W-1:0] off_o
);
  localparam logic [ROW_W-1:0] UPPER_FIRST = ROW_W'(ROWS / 2);

  logic [OFF_W-1:0] base;
  logic             upper;

  assign base  = (cas_lat_i == 2'd2) ? MRS_OFF_CL2 : MRS_OFF_CL3;
  assign upper = (row_i >= UPPER_FIRST);
  assign off_o = !is_mrs_i ? '0 : (upper ? (base ^ MRS_FLIP) : base);
endmodule

// File: rtl/sdram_row_walker.sv
module sdram_row_walker
  import sdram_bcast_pkg::*;
#(
  parameter int ROWS      = 8,
  parameter int BOUND_W   = 8,
  parameter int ROW_SHIFT = 23,
  parameter int ADDR_W    = 32,
  parameter int ROW_W     = $clog2(ROWS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    go_i,
  input  logic [CMD_W-1:0]        cmd_i,
  input  logic [ROWS*BOUND_W-1:0] bound_i,
  input  logic [OFF_W-1:0]        off_i,
  output logic [ROW_W-1:0]        row_o,
  output logic                    is_mrs_o,
  output logic                    busy_o,
  output logic                    rd_req_o,
  output logic [ADDR_W-1:0]       rd_addr_o,
  input  logic                    rd_ack_i,
  output logic                    done_o
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  walk_st_e           st_q;
  logic [ROW_W-1:0]   row_q;
  logic [BOUND_W-1:0] start_q, end_q;
  logic [CMD_W-1:0]   cmd_q;
  logic [BOUND_W-1:0] row_end;
  logic               last;

  assign row_end  = bound_i[row_q*BOUND_W +: BOUND_W];
  assign last     = (row_q == LAST_ROW);
  assign row_o    = row_q;
  assign is_mrs_o = (cmd_q == CMD_MRS);
  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = (st_q == ST_FIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      row_q     <= '0;
      start_q   <= '0;
      end_q     <= '0;
      cmd_q     <= CMD_NORMAL;
      rd_req_o  <= 1'b0;
      rd_addr_o <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (go_i) begin
          cmd_q   <= cmd_i;
          row_q   <= '0;
          start_q <= '0;
          st_q    <= (cmd_i == CMD_NORMAL) ? ST_FIN : ST_ROW;
        end
        ST_ROW: begin
          end_q <= row_end;
          if (row_end > start_q) begin
            rd_req_o  <= 1'b1;
            rd_addr_o <= (ADDR_W'(start_q) << ROW_SHIFT) + ADDR_W'(off_i);
            st_q      <= ST_WAIT;
          end else begin
            start_q <= row_end;
            if (last) st_q <= ST_FIN;
            else      row_q <= row_q + 1'b1;
          end
        end
        ST_WAIT: if (rd_ack_i) begin
          rd_req_o <= 1'b0;
          start_q  <= end_q;
          if (last) st_q <= ST_FIN;
          else begin
            row_q <= row_q + 1'b1;
            st_q  <= ST_ROW;
          end
        end
        ST_FIN: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_normal_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_q == CMD_NORMAL) |-> !rd_req_o);
  p_req_rows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_req_o) |-> (end_q > start_q));
endmodule

// File: rtl/sdram_cmd_bcast.sv
module sdram_cmd_bcast
  import sdram_bcast_pkg::*;
#(
  parameter int ROWS      = 8,
  parameter int BOUND_W   = 8,
  parameter int ROW_SHIFT = 23,
  parameter int ADDR_W    = 32,
  parameter int REG_W     = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [2:0]              cmd_i,
  input  logic [1:0]              cas_lat_i,
  input  logic [REG_W-1:0]        ctrl_i,
  output logic                    ctrl_we_o,
  output logic [REG_W-1:0]        ctrl_wdata_o,
  input  logic [ROWS*BOUND_W-1:0] bound_i,
  output logic                    rd_req_o,
  output logic [ADDR_W-1:0]       rd_addr_o,
  input  logic                    rd_ack_i,
  output logic                    done_o
);
  localparam int ROW_W = $clog2(ROWS);

  logic             busy, go, is_mrs;
  logic [1:0]       cl_q;
  logic [ROW_W-1:0] row;
  logic [OFF_W-1:0] off;

  assign go = start_i && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cl_q <= 2'd3;
    else if (go)  cl_q <= cas_lat_i;
  end

  sdram_ctrl_merge #(.REG_W(REG_W)) u_merge (
    .clk_i, .rst_ni, .go_i(go), .cmd_i, .ctrl_i, .ctrl_we_o, .ctrl_wdata_o
  );

  sdram_mrs_offset #(.ROWS(ROWS), .ROW_W(ROW_W)) u_off (
    .row_i(row), .cas_lat_i(cl_q), .is_mrs_i(is_mrs), .off_o(off)
  );

  sdram_row_walker #(
    .ROWS(ROWS), .BOUND_W(BOUND_W), .ROW_SHIFT(ROW_SHIFT), .ADDR_W(ADDR_W), .ROW_W(ROW_W)
  ) u_walk (
    .clk_i, .rst_ni, .go_i(go), .cmd_i, .bound_i, .off_i(off), .row_o(row),
    .is_mrs_o(is_mrs), .busy_o(busy), .rd_req_o, .rd_addr_o, .rd_ack_i, .done_o
  );

  p_one_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i) |=> !ctrl_we_o);
endmodule

// File: tb/sdram_cmd_bcast_bench.sv
module sdram_cmd_bcast_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [1:0]  cl = 2'd3;
  logic [15:0] ctrl = 16'h0;
  logic        ctrl_we;
  logic [15:0] ctrl_wdata;
  logic [63:0] bound = '0;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_ack = 1'b0;
  logic        done;

  int total = 0, bad = 0;
  logic [31:0] got [0:15];
  int got_n = 0, we_n = 0, dly = 0;
  logic [7:0] pat [0:4][0:7];

  always #2.5 clk = ~clk;

  sdram_cmd_bcast u_sdram_cmd_bcast (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd), .cas_lat_i(cl),
    .ctrl_i(ctrl), .ctrl_we_o(ctrl_we), .ctrl_wdata_o(ctrl_wdata), .bound_i(bound),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // responder: records each read, acknowledges after a varying delay (R9)
  initial forever begin
    @(negedge clk);
    if (rd_req) begin
      if (got_n < 16) got[got_n] = rd_addr;
      got_n++;
      repeat (dly) begin
        @(negedge clk);
        chk(rd_req && rd_addr == got[got_n-1], "R9 hold", rd_addr, got[got_n-1]);
      end
      rd_ack = 1'b1;
      @(negedge clk);
      rd_ack = 1'b0;
      dly = (dly + 1) % 3;
    end
  end

  always @(negedge clk) if (ctrl_we) we_n++;

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [31:0] exp_off(input logic [2:0] c, input logic [1:0] l, input int r);
    logic [31:0] b;
    if (c != 3'b011) return 32'h0;
    b = (l == 2'd2) ? 32'h150 : 32'h1D0;
    if (r >= 4) b = (l == 2'd2) ? 32'h1EA8 : 32'h1E28;
    return b;
  endfunction

  task automatic run_op(input int p, input logic [2:0] c, input logic [1:0] l,
                        input logic [15:0] cv, input bit poke);
    logic [31:0] ea [0:7];
    int en_n, st, t;
    logic [15:0] ew;
    string tag;
    en_n = 0; st = 0;
    for (int r = 0; r < 8; r++) begin
      bound[r*8 +: 8] = pat[p][r];
      if (c != 3'b000 && int'(pat[p][r]) > st) begin
        ea[en_n] = (32'(st) << 23) + exp_off(c, l, r);
        en_n++;
      end
      st = int'(pat[p][r]);
    end
    ew = (cv & 16'hFF1F) | (16'(c) << 5);
    @(negedge clk);
    got_n = 0; we_n = 0;
    cmd = c; cl = l; ctrl = cv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ctrl = ~cv;
    chk(ctrl_we && ctrl_wdata == ew, "R2 wdata", {15'h0, ctrl_we, ctrl_wdata}, {16'h1, ew});
    t = 0;
    while (!done && t < 200) begin
      @(negedge clk);
      t++;
      if (poke && t == 3) begin
        cmd = 3'b000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t++;
      end
    end
    chk(done == 1'b1, "R10 done", 32'(done), 32'h1);
    tag = (c == 3'b000) ? "R3 normal count" : "R5 read count";
    chk(got_n == en_n, tag, 32'(got_n), 32'(en_n));
    for (int i = 0; i < en_n && i < got_n; i++) begin
      if (c == 3'b011) tag = (l == 2'd2) ? "R8 mrs addr" : "R7 mrs addr";
      else             tag = "R6 addr";
      chk(got[i] == ea[i], {tag, " R4"}, got[i], ea[i]);
    end
    @(negedge clk);
    chk(!done && !rd_req, "R10 pulse", {30'h0, done, rd_req}, 32'h0);
    chk(we_n == 1, "R10 single write", 32'(we_n), 32'h1);
  endtask

  initial begin
    for (int r = 0; r < 8; r++) begin
      pat[0][r] = 8'd0;
      pat[1][r] = 8'(8 * (r + 1));
      pat[2][r] = 8'(4 + 8 * (r / 2));
      pat[4][r] = (r == 7) ? 8'd200 : 8'd0;
    end
    pat[3][0] = 8'd10;  pat[3][1] = 8'd5;  pat[3][2] = 8'd5;  pat[3][3] = 8'd20;
    pat[3][4] = 8'd20;  pat[3][5] = 8'd255; pat[3][6] = 8'd0; pat[3][7] = 8'd3;
    repeat (3) @(negedge clk);
    chk(!ctrl_we && !rd_req && !done, "R1 reset", {29'h0, ctrl_we, rd_req, done}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ctrl_we && !rd_req && !done, "R1 idle", {29'h0, ctrl_we, rd_req, done}, 32'h0);
    for (int p = 0; p < 5; p++)
      for (int c = 0; c < 8; c++)
        for (int l = 0; l < 4; l++)
          run_op(p, 3'(c), 2'(l), 16'(16'hA5C3 ^ (p * 16'h1111) ^ (c << 9) ^ l), 1'b0);
    run_op(1, 3'b001, 2'd3, 16'hFFFF, 1'b1);
    run_op(3, 3'b011, 2'd2, 16'h0000, 1'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule